// File: doc/BRIEF.md
# LPC Peripheral Standby and Wake Controller

This block governs the power state of a peripheral attached to a Low Pin Count host bus. It watches the host reset line, the host power-down line and the frame line, plus a one-cycle strobe from the bus decoder that marks a host standby command. From these it decides when the device is held in reset, when the communication buffer must be wiped, when the device sits in standby with the buffer kept, and when the local CPU is woken by an interrupt.

There are two ways into standby and each has its own way out. A falling power-down line, with auxiliary power present, enters power-down standby, which ends on the next rising edge of the host reset line. A host standby command enters command standby, which ends on the next falling edge of the frame line. Leaving either standby raises a wake interrupt that stays up until the CPU acknowledges it. A host reset held low long enough wipes the buffer and holds the device in reset, except in power-down standby, where a low reset line is the expected companion of power removal and the buffer survives.

The three host lines are asynchronous and pass through two flip-flops before edge detection. The minimum accepted reset pulse is set by the clock rate and a minimum width in nanoseconds.

Top module: `lpc_pwr_ctrl`

## Requirements
- R1: After the local power-on reset the block is in the reset state: dev_rst is 1, standby and wake_irq are 0, and no buf_clear pulse is issued; it leaves the reset state when the synchronised host reset line is first seen high.
- R2: A host reset line held low for at least RST_MIN_CYC synchronised cycles (33 at the defaults) while active or in command standby enters the reset state: dev_rst goes to 1, buf_clear is 1 for exactly one cycle on entry and wake_irq is cleared; a low pulse one cycle shorter has no effect.
- R3: A falling edge of the host power-down line while active with aux_ok at 1 enters power-down standby (standby 1, no buf_clear); with aux_ok at 0 the block stays active.
- R4: In power-down standby a low host reset line, of any length, neither asserts dev_rst nor pulses buf_clear; the next rising edge of the host reset line returns to active and sets wake_irq.
- R5: A stby_cmd strobe while active enters command standby (standby 1, dev_rst 0, no buf_clear).
- R6: In command standby a falling edge of the frame line returns to active and sets wake_irq; a frame edge in power-down standby or while active changes nothing.
- R7: A stby_cmd strobe in either standby state or in the reset state is ignored.
- R8: wake_irq stays 1 until a cycle with wake_ack at 1; when a wake event and wake_ack fall in the same cycle, wake_irq stays 1.
- R9: When events coincide while active, a qualified host reset wins over a power-down edge, which wins over a standby command.
- R10: A change on any host line, driven between clock edges, reaches the outputs on the third rising clock edge after it (two synchroniser stages plus the state register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| por_n | input | 1 | Local power-on reset, active low |
| host_rst_n | input | 1 | Asynchronous host reset line, active low |
| host_pd_n | input | 1 | Asynchronous host power-down line, active low |
| host_frame_n | input | 1 | Asynchronous frame line, active low |
| aux_ok | input | 1 | Auxiliary power present |
| stby_cmd | input | 1 | One-cycle strobe: host standby command decoded |
| wake_ack | input | 1 | CPU acknowledge of the wake interrupt |
| dev_rst | output | 1 | Device reset request |
| buf_clear | output | 1 | One-cycle request to destroy the buffer contents |
| standby | output | 1 | Device is in either standby state |
| wake_irq | output | 1 | Wake interrupt to the local CPU |

## Verification
Two pairs of functions can meet in one cycle: a wake event from command standby against the CPU acknowledge, and a standby entry against a qualified reset or a second entry path. The bench counts synchroniser stages to place the frame edge so its wake event lands on the same rising edge as wake_ack, and expects the interrupt to remain set; it places a power-down edge and a command strobe, and a reset qualification and a command strobe, on one edge and expects the higher-priority outcome of R9. Random sequences of commands, frame edges, power-down and reset pulses of both lengths, and acknowledges are compared against a bench model after each operation.

// File: rtl/lpc_pwr_pkg.sv
package lpc_pwr_pkg;

  typedef enum logic [1:0] {
    PS_ACTIVE   = 2'd0,
    PS_STBY_PD  = 2'd1,
    PS_STBY_CMD = 2'd2,
    PS_RESET    = 2'd3
  } pwr_state_e;

  typedef struct packed {
    logic rst_qual;   // host reset low long enough
    logic rst_rise;   // host reset released
    logic pd_fall;    // power-down requested
    logic frame_fall; // frame started
    logic cmd;        // standby command strobe
    logic aux_ok;     // auxiliary power present
  } pwr_ev_t;

  // cycles of clk covering min_ns, rounded up
  function automatic int unsigned min_cycles(input int unsigned clk_khz,
                                             input int unsigned min_ns);
    return (clk_khz * min_ns + 999999) / 1000000;
  endfunction

  function automatic pwr_state_e next_state(input pwr_state_e s, input pwr_ev_t ev);
    pwr_state_e n;
    n = s;
    case (s)
      PS_RESET:    if (ev.rst_rise) n = PS_ACTIVE;
      PS_ACTIVE: begin
        if (ev.rst_qual)                 n = PS_RESET;
        else if (ev.pd_fall && ev.aux_ok) n = PS_STBY_PD;
        else if (ev.cmd)                  n = PS_STBY_CMD;
      end
      PS_STBY_CMD: begin
        if (ev.rst_qual)        n = PS_RESET;
        else if (ev.frame_fall) n = PS_ACTIVE;
      end
      PS_STBY_PD:  if (ev.rst_rise) n = PS_ACTIVE;
      default:     n = PS_RESET;
    endcase
    return n;
  endfunction

  function automatic logic is_wake(input pwr_state_e s, input pwr_state_e n);
    return ((s == PS_STBY_PD) || (s == PS_STBY_CMD)) && (n == PS_ACTIVE);
  endfunction

  function automatic logic is_rst_entry(input pwr_state_e s, input pwr_state_e n);
    return (s != PS_RESET) && (n == PS_RESET);
  endfunction

endpackage

// File: rtl/lpc_pwr_sync.sv
module lpc_pwr_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [W-1:0] stg1;
  logic [W-1:0] stg2;
  logic [W-1:0] prev;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        stg1[i] <= RST_VAL[i];
        stg2[i] <= RST_VAL[i];
        prev[i] <= RST_VAL[i];
      end else begin
        stg1[i] <= async_in[i];
        stg2[i] <= stg1[i];
        prev[i] <= stg2[i];
      end
    end

    assign lvl[i]  = stg2[i];
    assign rise[i] = stg2[i] & ~prev[i];
    assign fall[i] = ~stg2[i] & prev[i];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
      rise[i] |=> !rise[i]); // R10
    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
      fall[i] |=> !fall[i]); // R10
  end

endmodule

// File: rtl/lpc_pwr_rstq.sv
module lpc_pwr_rstq #(
  parameter int unsigned MIN_CYC = 33
) (
  input  logic clk,
  input  logic por_n,
  input  logic lvl_n,
  output logic qual
);

  localparam int unsigned CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);
  localparam logic [CW-1:0] TOP  = CW'(MIN_CYC);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)             low_cnt <= '0;
    else if (lvl_n)         low_cnt <= '0;
    else if (low_cnt < TOP) low_cnt <= low_cnt + 1'b1;
  end

  assign qual = !lvl_n && (low_cnt == LAST);

  AST_QUAL_NEEDS_LOW: assert property (@(posedge clk) disable iff (!por_n)
    qual |-> !lvl_n && $past(!lvl_n)); // R2
  AST_QUAL_ONCE: assert property (@(posedge clk) disable iff (!por_n)
    qual |=> !qual); // R2

endmodule

// File: rtl/lpc_pwr_fsm.sv
module lpc_pwr_fsm
  import lpc_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  pwr_ev_t    ev,
  input  logic       ack,
  output pwr_state_e state,
  output logic       wake_irq,
  output logic       buf_clear
);

  pwr_state_e nxt;
  logic       wake_ev;
  logic       rst_entry;

  always_comb begin
    nxt       = next_state(state, ev);
    wake_ev   = is_wake(state, nxt);
    rst_entry = is_rst_entry(state, nxt);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state     <= PS_RESET;
      wake_irq  <= 1'b0;
      buf_clear <= 1'b0;
    end else begin
      state     <= nxt;
      buf_clear <= rst_entry;
      if (rst_entry)    wake_irq <= 1'b0;
      else if (wake_ev) wake_irq <= 1'b1;
      else if (ack)     wake_irq <= 1'b0;
    end
  end

  AST_RST_WINS: assert property (@(posedge clk) disable iff (!por_n)
    ev.rst_qual && (state == PS_ACTIVE || state == PS_STBY_CMD)
      |=> state == PS_RESET && buf_clear && !wake_irq); // R2
  AST_BUFCLR_PULSE: assert property (@(posedge clk) disable iff (!por_n)
    buf_clear |=> !buf_clear); // R2
  AST_PD_KEEP: assert property (@(posedge clk) disable iff (!por_n)
    state == PS_STBY_PD && !ev.rst_rise |=> state == PS_STBY_PD && !buf_clear); // R4
  AST_PD_WAKE: assert property (@(posedge clk) disable iff (!por_n)
    state == PS_STBY_PD && ev.rst_rise |=> state == PS_ACTIVE && wake_irq); // R4
  AST_CMD_WAKE: assert property (@(posedge clk) disable iff (!por_n)
    state == PS_STBY_CMD && ev.frame_fall && !ev.rst_qual
      |=> state == PS_ACTIVE && wake_irq); // R6
  AST_CMD_IGNORED: assert property (@(posedge clk) disable iff (!por_n)
    state != PS_ACTIVE && ev.cmd && !ev.frame_fall && !ev.rst_rise && !ev.rst_qual
      |=> $stable(state)); // R7
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!por_n)
    wake_irq && !ack |=> wake_irq || state == PS_RESET); // R8
  AST_PD_OVER_CMD: assert property (@(posedge clk) disable iff (!por_n)
    state == PS_ACTIVE && !ev.rst_qual && ev.pd_fall && ev.aux_ok && ev.cmd
      |=> state == PS_STBY_PD); // R9

endmodule

// File: rtl/lpc_pwr_ctrl.sv
module lpc_pwr_ctrl
  import lpc_pwr_pkg::*;
#(
  parameter int unsigned CLK_KHZ    = 33000,
  parameter int unsigned RST_MIN_NS = 1000
) (
  input  logic clk,
  input  logic por_n,
  input  logic host_rst_n,
  input  logic host_pd_n,
  input  logic host_frame_n,
  input  logic aux_ok,
  input  logic stby_cmd,
  input  logic wake_ack,
  output logic dev_rst,
  output logic buf_clear,
  output logic standby,
  output logic wake_irq
);

  localparam int unsigned RST_MIN_CYC = min_cycles(CLK_KHZ, RST_MIN_NS);
  localparam int          NLINE       = 3;
  localparam int          IX_RST      = 0;
  localparam int          IX_PD       = 1;
  localparam int          IX_FRM      = 2;
  // reset line assumed asserted at power-on, others idle high
  localparam logic [NLINE-1:0] SYNC_RST = 3'b110;

  logic [NLINE-1:0] line_lvl;
  logic [NLINE-1:0] line_rise;
  logic [NLINE-1:0] line_fall;

  // named internal events
  logic       ev_rst_qual;
  logic       ev_rst_rise;
  logic       ev_pd_fall;
  logic       ev_frame_fall;
  pwr_ev_t    ev;
  pwr_state_e state;

  lpc_pwr_sync #(.W(NLINE), .RST_VAL(SYNC_RST)) u_sync (
    .clk      (clk),
    .por_n    (por_n),
    .async_in ({host_frame_n, host_pd_n, host_rst_n}),
    .lvl      (line_lvl),
    .rise     (line_rise),
    .fall     (line_fall)
  );

  lpc_pwr_rstq #(.MIN_CYC(RST_MIN_CYC)) u_rstq (
    .clk   (clk),
    .por_n (por_n),
    .lvl_n (line_lvl[IX_RST]),
    .qual  (ev_rst_qual)
  );

  assign ev_rst_rise   = line_rise[IX_RST];
  assign ev_pd_fall    = line_fall[IX_PD];
  assign ev_frame_fall = line_fall[IX_FRM];

  always_comb begin
    ev.rst_qual   = ev_rst_qual;
    ev.rst_rise   = ev_rst_rise;
    ev.pd_fall    = ev_pd_fall;
    ev.frame_fall = ev_frame_fall;
    ev.cmd        = stby_cmd;
    ev.aux_ok     = aux_ok;
  end

  lpc_pwr_fsm u_fsm (
    .clk       (clk),
    .por_n     (por_n),
    .ev        (ev),
    .ack       (wake_ack),
    .state     (state),
    .wake_irq  (wake_irq),
    .buf_clear (buf_clear)
  );

  assign dev_rst = (state == PS_RESET);
  assign standby = (state == PS_STBY_PD) || (state == PS_STBY_CMD);

  AST_BUFCLR_IN_RST: assert property (@(posedge clk) disable iff (!por_n)
    buf_clear |-> dev_rst); // R2
  AST_CMD_ENTRY: assert property (@(posedge clk) disable iff (!por_n)
    state == PS_ACTIVE && stby_cmd && !ev_rst_qual && !(ev_pd_fall && aux_ok)
      |=> standby && !dev_rst && !buf_clear); // R5
  AST_NOAUX_STAY: assert property (@(posedge clk) disable iff (!por_n)
    state == PS_ACTIVE && ev_pd_fall && !aux_ok && !stby_cmd && !ev_rst_qual
      |=> !standby && !dev_rst); // R3

endmodule

// File: tb/lpc_pwr_ctrl_tb.sv
`timescale 1ns/1ps
module lpc_pwr_ctrl_tb;

  function automatic int bench_min(input int khz, input int ns);
    int t;
    t = khz * ns;
    return (t % 1000000 == 0) ? t / 1000000 : t / 1000000 + 1;
  endfunction

  localparam int MIN = bench_min(33000, 1000);

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic host_rst_n = 1'b0, host_pd_n = 1'b1, host_frame_n = 1'b1;
  logic aux_ok = 1'b1, stby_cmd = 1'b0, wake_ack = 1'b0;
  logic dev_rst, buf_clear, standby, wake_irq;

  int checks = 0, fails = 0, bc_cnt = 0;
  bit done = 0;
  int exp_st = 0;   // 0 active, 1 pd standby, 2 cmd standby
  int exp_irq = 0;
  int exp_bc = 0;

  always #10 clk = ~clk;

  lpc_pwr_ctrl u_dut (
    .clk(clk), .por_n(por_n), .host_rst_n(host_rst_n), .host_pd_n(host_pd_n),
    .host_frame_n(host_frame_n), .aux_ok(aux_ok), .stby_cmd(stby_cmd),
    .wake_ack(wake_ack), .dev_rst(dev_rst), .buf_clear(buf_clear),
    .standby(standby), .wake_irq(wake_irq)
  );

  always @(negedge clk) if (buf_clear === 1'b1) bc_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_model(input string req);
    chk({req, " standby"}, standby, (exp_st != 0));
    chk({req, " dev_rst"}, dev_rst, 0);
    chk({req, " wake_irq"}, wake_irq, exp_irq);
    chk({req, " buf_clear count"}, bc_cnt, exp_bc);
  endtask

  task automatic op_cmd();
    stby_cmd = 1; tick(1); stby_cmd = 0; tick(5);
    if (exp_st == 0) exp_st = 2;                       // R5, R7
  endtask

  task automatic op_frame();
    host_frame_n = 0; tick(2); host_frame_n = 1; tick(5);
    if (exp_st == 2) begin exp_st = 0; exp_irq = 1; end // R6
  endtask

  task automatic op_pd(input logic aux);
    aux_ok = aux; host_pd_n = 0; tick(4); host_pd_n = 1; tick(5);
    if (exp_st == 0 && aux) exp_st = 1;                // R3
  endtask

  task automatic op_rst(input int len);
    host_rst_n = 0; tick(len); host_rst_n = 1; tick(5);
    if (exp_st == 1) begin exp_st = 0; exp_irq = 1; end // R4
    else if (len >= MIN) begin exp_st = 0; exp_irq = 0; exp_bc++; end // R2
  endtask

  task automatic op_ack();
    wake_ack = 1; tick(1); wake_ack = 0; tick(1);
    exp_irq = 0;                                       // R8
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    tick(3);
    por_n = 1;
    // R1: held in reset while host reset low
    tick(MIN + 20);
    chk("R1 dev_rst at start", dev_rst, 1);
    chk("R1 standby at start", standby, 0);
    chk("R1 wake_irq at start", wake_irq, 0);
    chk("R1 no buf_clear at start", bc_cnt, 0);
    // R7: command ignored in reset state
    stby_cmd = 1; tick(1); stby_cmd = 0; tick(2);
    chk("R7 cmd in reset", standby, 0);
    host_rst_n = 1; tick(5);
    chk("R1 leave reset", dev_rst, 0);
    chk_model("R1 active after release");

    // R5 and R10 latency
    op_cmd();
    chk_model("R5 command standby");
    host_frame_n = 0;
    tick(2);
    chk("R10 still standby after two edges", standby, 1);
    tick(1);
    chk("R10 awake on third edge", standby, 0);
    chk("R6 wake_irq set", wake_irq, 1);
    host_frame_n = 1; tick(3);
    exp_st = 0; exp_irq = 1;
    op_ack();
    chk_model("R8 ack clears");

    // R2 boundary lengths
    op_rst(MIN - 1);
    chk_model("R2 short pulse ignored");
    host_rst_n = 0; tick(MIN + 4);
    chk("R2 dev_rst during long pulse", dev_rst, 1);
    chk("R2 one buf_clear", bc_cnt, exp_bc + 1);
    host_rst_n = 1; tick(5);
    exp_bc++;
    chk_model("R2 after long pulse");

    // R3 aux absent, then present
    op_pd(0);
    chk_model("R3 no aux stays active");
    op_pd(1);
    chk_model("R3 pd standby");

    // R4 long low in pd standby keeps buffer, R7 and R6 ignored there
    op_cmd();
    chk_model("R7 cmd in pd standby");
    op_frame();
    chk_model("R6 frame in pd standby");
    host_rst_n = 0; tick(MIN + 10);
    chk("R4 no dev_rst in pd standby", dev_rst, 0);
    chk("R4 still standby", standby, 1);
    host_rst_n = 1; tick(5);
    exp_st = 0; exp_irq = 1;
    chk_model("R4 wake on reset rise");

    // R8 wake and ack on the same edge (irq already 1)
    op_cmd();
    chk_model("R8 cmd standby with irq pending");
    host_frame_n = 0; tick(2);
    wake_ack = 1; tick(1); wake_ack = 0;
    host_frame_n = 1;
    chk("R8 irq kept on coincident ack", wake_irq, 1);
    chk("R8 active after wake", standby, 0);
    tick(3);
    op_ack();
    exp_st = 0;
    chk_model("R8 cleared by later ack");

    // R9 power-down edge with command on same edge
    aux_ok = 1; host_pd_n = 0; tick(2);
    stby_cmd = 1; tick(1); stby_cmd = 0; tick(2);
    host_pd_n = 1; tick(3);
    exp_st = 1;
    chk_model("R9 pd over cmd");
    op_rst(3);
    op_ack();
    chk_model("R9 back to active");

    // R9 qualified reset with command on same edge
    host_rst_n = 0; tick(MIN + 1);
    stby_cmd = 1; tick(1); stby_cmd = 0; tick(2);
    chk("R9 reset over cmd", dev_rst, 1);
    chk("R9 reset over cmd standby", standby, 0);
    host_rst_n = 1; tick(5);
    exp_bc++; exp_st = 0; exp_irq = 0;
    chk_model("R9 after reset");

    // random sequence
    for (int i = 0; i < 80; i++) begin
      int unsigned r;
      r = $urandom % 7;
      case (r)
        0: begin op_cmd();   chk_model("R5 R7 random cmd"); end
        1: begin op_frame(); chk_model("R6 random frame"); end
        2: begin op_pd($urandom % 2 == 1); chk_model("R3 random pd"); end
        3: begin op_rst(MIN + ($urandom % 8)); chk_model("R2 R4 random long reset"); end
        4: begin op_rst(1 + ($urandom % (MIN - 1))); chk_model("R2 R4 random short reset"); end
        5: begin op_ack();   chk_model("R8 random ack"); end
        default: begin tick(1 + $urandom % 4); chk_model("R8 random idle"); end
      endcase
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule